// File: doc/BRIEF.md
# Serial Management Master on a Shared Transmit Line

This block reads and writes PHY registers over a two-wire management link (MDC clock and MDIO data). The management data line has no pin of its own. It shares one physical line with bit 0 of the transmit data bus. While the block is idle, the transmit path's TXD0 value passes straight through to the shared pin, which stays an output. While a management transfer runs, the block takes over the pin. During the turnaround and data bits of a register read, the block releases the pin so that the PHY can drive it.

A request arrives on a command channel that uses valid/ready handshaking. The request carries the operation, a 5-bit PHY address, a 5-bit register address and 16 bits of write data. The block lowers `cmd_ready` whenever it cannot take a command: while a transfer is in progress, and in any cycle where the transmit path holds TX_EN high. A caller keeps `cmd_valid` and its fields steady until it sees the handshake.

The result is reported by `rsp_valid`, a single-cycle pulse that accepts no back-pressure. After a read, `rsp_rdata` holds the value until the next read replaces it. The block drives `mgmt_busy` to the transmit path, which must not start a frame while it is high. If TX_EN rises anyway, MDC freezes and the transfer waits. The MDC half period equals `div_half` system clocks, so a value of 10 at 50 MHz gives a 400 ns bit.

Top module: `mgmt_serial_master`

## Requirements
- R1: Each transfer shifts out 64 bits, most significant first: 32 ones, start pattern 0 then 1, opcode (read = 1,0; write = 0,1), the 5-bit PHY address, the 5-bit register address, two turnaround bits and 16 data bits.
- R2: Each MDC half period lasts `div_half` system clocks, with MDC starting low. `rsp_valid` rises exactly 128·`div_half` clocks after the accepting edge, plus any clocks during which TX_EN was high.
- R3: The block changes its data bit only when MDC falls. While MDC is high, the driven value is stable.
- R4: On a read, `pin_oe` is 1 for bits 0–45 and 0 for bits 46–63. The line is sampled on MDC rising edges during bits 48–63 and returned MSB-first on `rsp_rdata`.
- R5: On a write, `pin_oe` stays 1 for all 64 bits, with turnaround bits 1 then 0 followed by the write data.
- R6: A command is accepted only when the block is idle and TX_EN is low in the same cycle. If TX_EN and `cmd_valid` rise together, the transmit path wins.
- R7: `mgmt_busy` rises on the accepting edge and falls on the edge that raises `rsp_valid`.
- R8: While TX_EN is high, MDC does not change level.
- R9: When idle, MDC is low, `pin_oe` is 1 and `pin_out` equals `tx_d0_in`.
- R10: `rsp_valid` is high for exactly one cycle per transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command request present |
| cmd_ready | output | 1 | Command can be accepted this cycle |
| cmd_write | input | 1 | 1 = register write, 0 = register read |
| cmd_phy | input | 5 | PHY address |
| cmd_reg | input | 5 | Register address |
| cmd_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Data of the last read |
| div_half | input | 8 | System clocks per MDC half period |
| tx_en_in | input | 1 | Transmit enable from the transmit path |
| tx_d0_in | input | 1 | Transmit data bit 0 from the transmit path |
| mgmt_busy | output | 1 | Transfer in progress; transmit path holds off |
| mdc | output | 1 | Management clock |
| pin_out | output | 1 | Value for the shared line |
| pin_oe | output | 1 | Output enable for the shared line |
| pin_in | input | 1 | Value read back from the shared line |

## Verification
Two pairs of events can fall in the same cycle.

- **Command acceptance and a transmit start.** The bench raises `cmd_valid` and TX_EN on the same edge. It then checks that `mgmt_busy` stays low, that the pin still carries TXD0, and that the command is taken only after TX_EN drops.
- **An MDC step and TX_EN going high mid-transfer.** The bench raises TX_EN partway through a read. It checks that MDC holds its level on every stalled cycle, that completion is delayed by exactly the stall length, and that the decoded frame and the returned read data are still correct.

// File: rtl/mgmt_pkg.sv
package mgmt_pkg;
  localparam int PRE_BITS   = 32;
  localparam int ADDR_W     = 5;
  localparam int DATA_W     = 16;
  localparam int FRAME_BITS = PRE_BITS + 2 + 2 + 2 * ADDR_W + 2 + DATA_W;
  localparam int CNT_W      = $clog2(FRAME_BITS);
  localparam int RD_DRIVE   = FRAME_BITS - DATA_W - 2;
  localparam int DATA_START = FRAME_BITS - DATA_W;

  localparam logic [1:0] START_PAT = 2'b01;
  localparam logic [1:0] OPC_WR    = 2'b01;
  localparam logic [1:0] OPC_RD    = 2'b10;
  localparam logic [1:0] TA_WR     = 2'b10;

  function automatic logic [FRAME_BITS-1:0] build_frame(
    input logic              wr,
    input logic [ADDR_W-1:0] phy,
    input logic [ADDR_W-1:0] regad,
    input logic [DATA_W-1:0] wd
  );
    logic [1:0]        opc;
    logic [1:0]        ta;
    logic [DATA_W-1:0] dat;
    opc = wr ? OPC_WR : OPC_RD;
    ta  = wr ? TA_WR : 2'b00;
    dat = wr ? wd : '0;
    return {{PRE_BITS{1'b1}}, START_PAT, opc, phy, regad, ta, dat};
  endfunction
endpackage

// File: rtl/mgmt_mdc_gen.sv
module mgmt_mdc_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             hold,
  input  logic [DIV_W-1:0] div_half,
  output logic             mdc,
  output logic             rise_tick,
  output logic             fall_tick
);
  logic [DIV_W-1:0] cnt;
  logic             last;
  logic             step;

  // a half period ends when the count reaches div_half-1 (0 behaves as 1)
  always_comb begin
    last      = ({1'b0, cnt} + (DIV_W+1)'(1)) >= {1'b0, div_half};
    step      = run && !hold && last;
    rise_tick = step && !mdc;
    fall_tick = step && mdc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (!run) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (!hold) begin
      if (last) begin
        cnt <= '0;
        mdc <= ~mdc;
      end else begin
        cnt <= cnt + DIV_W'(1);
      end
    end
  end

  // R8: transmit enable freezes the management clock
  p_mdc_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (run && hold) |=> $stable(mdc));
endmodule

// File: rtl/mgmt_frame_seq.sv
module mgmt_frame_seq
  import mgmt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              start_write,
  input  logic [ADDR_W-1:0] start_phy,
  input  logic [ADDR_W-1:0] start_reg,
  input  logic [DATA_W-1:0] start_wdata,
  input  logic              rise_tick,
  input  logic              fall_tick,
  input  logic              line_in,
  output logic              busy,
  output logic              line_out,
  output logic              line_drive,
  output logic [DATA_W-1:0] rd_data,
  output logic              done
);
  localparam logic [CNT_W-1:0] LAST_IDX  = CNT_W'(FRAME_BITS - 1);
  localparam logic [CNT_W-1:0] DATA_IDX  = CNT_W'(DATA_START);
  localparam logic [CNT_W-1:0] DRIVE_END = CNT_W'(RD_DRIVE);

  logic [FRAME_BITS-1:0] sr;
  logic [CNT_W-1:0]      bitcnt;
  logic                  is_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr      <= '0;
      bitcnt  <= '0;
      is_wr   <= 1'b0;
      busy    <= 1'b0;
      rd_data <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start && !busy) begin
        busy   <= 1'b1;
        is_wr  <= start_write;
        bitcnt <= '0;
        sr     <= build_frame(start_write, start_phy, start_reg, start_wdata);
      end else if (busy) begin
        if (rise_tick && !is_wr && bitcnt >= DATA_IDX)
          rd_data <= {rd_data[DATA_W-2:0], line_in};
        if (fall_tick) begin
          if (bitcnt == LAST_IDX) begin
            busy <= 1'b0;
            done <= 1'b1;
          end else begin
            bitcnt <= bitcnt + CNT_W'(1);
            sr     <= {sr[FRAME_BITS-2:0], 1'b0};
          end
        end
      end
    end
  end

  always_comb begin
    line_out   = sr[FRAME_BITS-1];
    line_drive = busy && (is_wr || bitcnt < DRIVE_END);
  end

  // R10: completion is a single-cycle pulse
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R7: busy drops exactly with the completion pulse
  p_busy_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
endmodule

// File: rtl/mgmt_pin_mux.sv
module mgmt_pin_mux (
  input  logic owns,
  input  logic mgmt_line,
  input  logic mgmt_drive,
  input  logic tx_d0,
  output logic pin_out,
  output logic pin_oe
);
  always_comb begin
    pin_out = owns ? mgmt_line : tx_d0;
    pin_oe  = owns ? mgmt_drive : 1'b1;
  end
endmodule

// File: rtl/mgmt_serial_master.sv
module mgmt_serial_master
  import mgmt_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic              cmd_write,
  input  logic [ADDR_W-1:0] cmd_phy,
  input  logic [ADDR_W-1:0] cmd_reg,
  input  logic [DATA_W-1:0] cmd_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  input  logic [DIV_W-1:0]  div_half,
  input  logic              tx_en_in,
  input  logic              tx_d0_in,
  output logic              mgmt_busy,
  output logic              mdc,
  output logic              pin_out,
  output logic              pin_oe,
  input  logic              pin_in
);
  logic start;
  logic rise_tick;
  logic fall_tick;
  logic mgmt_line;
  logic mgmt_drive;

  always_comb begin
    cmd_ready = !mgmt_busy && !tx_en_in;
    start     = cmd_valid && cmd_ready;
  end

  mgmt_mdc_gen #(.DIV_W(DIV_W)) i_mdc (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (mgmt_busy),
    .hold     (tx_en_in),
    .div_half (div_half),
    .mdc      (mdc),
    .rise_tick(rise_tick),
    .fall_tick(fall_tick)
  );

  mgmt_frame_seq i_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .start_write(cmd_write),
    .start_phy  (cmd_phy),
    .start_reg  (cmd_reg),
    .start_wdata(cmd_wdata),
    .rise_tick  (rise_tick),
    .fall_tick  (fall_tick),
    .line_in    (pin_in),
    .busy       (mgmt_busy),
    .line_out   (mgmt_line),
    .line_drive (mgmt_drive),
    .rd_data    (rsp_rdata),
    .done       (rsp_valid)
  );

  mgmt_pin_mux i_mux (
    .owns      (mgmt_busy),
    .mgmt_line (mgmt_line),
    .mgmt_drive(mgmt_drive),
    .tx_d0     (tx_d0_in),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe)
  );

  // R6: a transfer never begins on an edge where transmit enable was high
  p_no_start_in_tx_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mgmt_busy) |-> !$past(tx_en_in));
  // R9: the management clock rests low when idle
  p_idle_mdc_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !mgmt_busy |-> !mdc);
  // R3: the driven bit does not move while MDC stays high
  p_bit_stable_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mgmt_busy && mdc && $past(mgmt_busy && mdc)) |-> $stable(mgmt_line));
endmodule

// File: tb/test_mgmt_serial_master.sv
module test_mgmt_serial_master;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic        cmd_write = 1'b0;
  logic [4:0]  cmd_phy = '0;
  logic [4:0]  cmd_reg = '0;
  logic [15:0] cmd_wdata = '0;
  logic        rsp_valid;
  logic [15:0] rsp_rdata;
  logic [7:0]  div_half = 8'd1;
  logic        tx_en_in = 1'b0;
  logic        tx_d0_in = 1'b0;
  logic        mgmt_busy;
  logic        mdc;
  logic        pin_out;
  logic        pin_oe;
  logic        pin_in;
  logic        phy_val = 1'b1;
  logic [15:0] phy_word = '0;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int nrise = 0;
  logic        prev_mdc = 1'b0;
  logic [63:0] rx_bits;
  logic [63:0] rx_oe;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // shared line: the block drives it when enabled, otherwise the PHY model
  assign pin_in = pin_oe ? pin_out : phy_val;

  mgmt_serial_master i_mgmt_serial_master (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_write(cmd_write), .cmd_phy(cmd_phy), .cmd_reg(cmd_reg),
    .cmd_wdata(cmd_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .div_half(div_half), .tx_en_in(tx_en_in), .tx_d0_in(tx_d0_in),
    .mgmt_busy(mgmt_busy), .mdc(mdc), .pin_out(pin_out), .pin_oe(pin_oe),
    .pin_in(pin_in)
  );

  // PHY model: records the line on MDC rises, drives read bits after falls
  always @(negedge clk) begin
    if (mdc && !prev_mdc) begin
      if (nrise < 64) begin
        rx_bits[63-nrise] = pin_in;
        rx_oe[63-nrise]   = pin_oe;
      end
      nrise = nrise + 1;
    end
    if (!mdc && prev_mdc) begin
      if (nrise == 47) phy_val = 1'b0;
      else if (nrise >= 48 && nrise < 64) phy_val = phy_word[63-nrise];
      else phy_val = 1'b1;
    end
    prev_mdc = mdc;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic do_xfer(input bit wr, input logic [4:0] phy, input logic [4:0] rg,
                         input logic [15:0] wd, input logic [15:0] pw,
                         input int d, input int stall_at, input int stall_len);
    int t0;
    int waited;
    bit frozen_ok;
    logic m0;
    logic [63:0] exp_frame;
    logic [63:0] exp_oe;
    div_half = 8'(d);
    phy_word = pw;
    nrise    = 0;
    phy_val  = 1'b1;
    @(negedge clk);
    cmd_write = wr; cmd_phy = phy; cmd_reg = rg; cmd_wdata = wd; cmd_valid = 1'b1;
    while (!cmd_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    t0 = cyc;
    check(mgmt_busy === 1'b1, "R7", "busy after accept", 64'(mgmt_busy), 64'd1);
    waited = 0;
    frozen_ok = 1'b1;
    while (!rsp_valid && waited < 20000) begin
      if (stall_len > 0 && cyc == t0 + stall_at) begin
        tx_en_in = 1'b1;
        m0 = mdc;
        for (int k = 0; k < stall_len; k++) begin
          @(negedge clk);
          if (mdc !== m0) frozen_ok = 1'b0;
        end
        tx_en_in = 1'b0;
        check(frozen_ok, "R8", "MDC frozen during TX_EN", 64'(mdc), 64'(m0));
      end
      @(negedge clk);
      waited++;
    end
    check(cyc - t0 == 128 * d + stall_len, "R2", "transfer duration",
          64'(cyc - t0), 64'(128 * d + stall_len));
    exp_frame = {32'hFFFF_FFFF, 2'b01, (wr ? 2'b01 : 2'b10), phy, rg, 2'b10,
                 (wr ? wd : pw)};
    exp_oe = wr ? {64{1'b1}} : {{46{1'b1}}, 18'd0};
    check(nrise == 64, "R2", "MDC rising edges", 64'(nrise), 64'd64);
    check(rx_bits === exp_frame, wr ? "R5" : "R1", "frame on line", rx_bits, exp_frame);
    check(rx_oe === exp_oe, wr ? "R5" : "R4", "drive pattern", rx_oe, exp_oe);
    if (!wr) check(rsp_rdata === pw, "R4", "read data", 64'(rsp_rdata), 64'(pw));
    @(negedge clk);
    check(rsp_valid === 1'b0, "R10", "single-cycle done", 64'(rsp_valid), 64'd0);
    check(mgmt_busy === 1'b0, "R7", "busy cleared", 64'(mgmt_busy), 64'd0);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    int dlist[3];
    dlist = '{1, 2, 5};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state
    check(mgmt_busy === 1'b0, "R7", "reset busy", 64'(mgmt_busy), 64'd0);
    check(rsp_valid === 1'b0, "R10", "reset done", 64'(rsp_valid), 64'd0);
    check(mdc === 1'b0, "R9", "reset mdc", 64'(mdc), 64'd0);
    check(cmd_ready === 1'b1, "R6", "reset ready", 64'(cmd_ready), 64'd1);

    // R9: idle passthrough of TXD0
    for (int i = 0; i < 4; i++) begin
      tx_en_in = i[1];
      tx_d0_in = i[0];
      @(negedge clk);
      check(pin_out === tx_d0_in && pin_oe === 1'b1, "R9", "idle passthrough",
            64'({pin_oe, pin_out}), 64'({1'b1, tx_d0_in}));
    end
    tx_en_in = 1'b0;

    // R6: command raised together with TX_EN is held off
    @(negedge clk);
    cmd_valid = 1'b1; cmd_write = 1'b1; tx_en_in = 1'b1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      check(mgmt_busy === 1'b0 && cmd_ready === 1'b0, "R6", "hold off during TX_EN",
            64'({mgmt_busy, cmd_ready}), 64'd0);
    end
    check(pin_oe === 1'b1 && mdc === 1'b0, "R9", "pin kept by transmit path",
          64'({pin_oe, mdc}), 64'b10);
    cmd_valid = 1'b0;
    tx_en_in  = 1'b0;

    // sweep of PHY addresses, both operations, several divider settings
    for (int di = 0; di < 3; di++) begin
      for (int a = 0; a < 32; a++) begin
        do_xfer(1'b1, 5'(a), 5'(31 - a), 16'(a * 16'h0841) ^ 16'hA5C3, 16'h0, dlist[di], 0, 0);
        do_xfer(1'b0, 5'(a), 5'(a ^ 7), 16'h0, 16'(a * 16'h1357) ^ 16'h5A3C, dlist[di], 0, 0);
      end
    end

    // R8: TX_EN raised in the middle of a read
    do_xfer(1'b0, 5'd3, 5'd17, 16'h0, 16'hBEEF, 2, 41, 25);
    // R2: 400 ns bit at 50 MHz
    do_xfer(1'b1, 5'd31, 5'd0, 16'h8001, 16'h0, 10, 0, 0);
    do_xfer(1'b0, 5'd0, 5'd31, 16'h0, 16'hFFFF, 10, 0, 0);
    summary();
  end
endmodule